// File: doc/BRIEF.md
# Downstream Port Requester Access Checker

This block sits on the upstream-bound request path of a switch or root downstream port. It sees one request header at a time and applies access rules before the router acts on it. Each header carries three things: the requester's bus number, a flag that marks it as a completion rather than a request, and a flag that says whether its routing target is a peer port. For each header the block gives one of four verdicts:

- send upstream as normal,
- deliver directly to the peer,
- redirect upstream toward the root for validation,
- discard.

It also raises an error strobe when it discards a header.

Two checks decide the verdict. Source validation compares the requester bus number against the port's inclusive secondary-to-subordinate bus window. The peer policy then picks direct delivery, blocking or redirection for peer traffic. Each feature has its own enable input. A mask input silences the error strobe without changing the verdict.

Headers enter through a valid/ready handshake, and the verdict leaves through a registered valid/ready output stage. The error-reporting logic downstream counts the strobe.

Top module: `acs_dnport_checker`

## Requirements
- R1: After reset, `res_valid` and `acs_violation` are 0 and `hdr_ready` is 1.
- R2: A header accepted on a clock edge (`hdr_valid` and `hdr_ready` both 1) produces `res_valid`=1 with its verdict on the next edge. `hdr_ready` is 1 exactly when `res_valid` is 0 or `res_ready` is 1. While `res_valid`=1 and `res_ready`=0, the verdict holds.
- R3: With `cfg_src_check_en`=1, a request (`hdr_is_cpl`=0) whose `hdr_req_bus` is below `cfg_sec_bus` or above `cfg_sub_bus` gets verdict 2'b11 (discard). This applies whether or not it targets a peer. Bus numbers equal to either bound pass.
- R4: With `cfg_src_check_en`=0, the requester bus number has no effect on the verdict.
- R5: A peer request (`hdr_to_peer`=1, `hdr_is_cpl`=0) with `cfg_peer_block_en`=1 gets 2'b11, whatever the value of `cfg_req_redirect_en`.
- R6: A peer request with blocking off gets 2'b10 (redirect) when `cfg_req_redirect_en`=1, else 2'b01 (direct to peer).
- R7: A peer completion gets 2'b10 when `cfg_cpl_redirect_en`=1, else 2'b01. Neither blocking nor source validation affects a completion.
- R8: A header that is not for a peer and passes source validation gets 2'b00 (upstream).
- R9: `acs_violation` is 1 for exactly one cycle per discarded header: the cycle in which that header's verdict first appears on `res_valid`. It is 0 in every other cycle.
- R10: With `cfg_violation_mask`=1 at acceptance, a discarded header raises no `acs_violation`, but its verdict is still 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_sec_bus | input | BUS_W | Lowest bus number below this port |
| cfg_sub_bus | input | BUS_W | Highest bus number below this port |
| cfg_src_check_en | input | 1 | Enable requester bus validation |
| cfg_req_redirect_en | input | 1 | Redirect peer requests upstream |
| cfg_cpl_redirect_en | input | 1 | Redirect peer completions upstream |
| cfg_peer_block_en | input | 1 | Block peer requests |
| cfg_violation_mask | input | 1 | Suppress the error strobe |
| hdr_valid | input | 1 | Header present |
| hdr_ready | output | 1 | Header accepted this cycle if valid |
| hdr_req_bus | input | BUS_W | Requester bus number |
| hdr_is_cpl | input | 1 | Header is a completion |
| hdr_to_peer | input | 1 | Routing target is a peer port |
| res_valid | output | 1 | Verdict present |
| res_ready | input | 1 | Consumer takes the verdict |
| res_verdict | output | 2 | 00 upstream, 01 peer, 10 redirect, 11 discard |
| acs_violation | output | 1 | One-cycle strobe per unmasked discard |

## Verification
Bus numbers are driven just outside, exactly on, and well inside the window. This separates an inclusive compare from an exclusive or off-by-one compare, and an enabled check from a disabled one. Peer requests and completions are sent under every combination of block and redirect enables. This shows that blocking wins over redirection, and that completions ignore both blocking and source validation. The discard cases are repeated with the mask set and with the consumer stalling. This shows that the strobe fires once per discarded header, only in that header's first result cycle, and never when masked.

// File: rtl/acs_pkg.sv
`timescale 1ns/1ps
// Shared types for the downstream port access checker.
package acs_pkg;
    typedef enum logic [1:0] {
        VERD_UPSTREAM = 2'b00,
        VERD_PEER     = 2'b01,
        VERD_REDIRECT = 2'b10,
        VERD_DISCARD  = 2'b11
    } verdict_e;

    typedef struct packed {
        logic src_en;
        logic req_redir_en;
        logic cpl_redir_en;
        logic block_en;
        logic viol_mask;
    } acs_ctrl_t;
endpackage

// File: rtl/acs_range_check.sv
`timescale 1ns/1ps
// Bus window check: flags a requester bus outside [lo, hi] inclusive.
// Assumes lo <= hi when configured; with enable low it never flags.
module acs_range_check #(
    parameter int BUS_W = 8
) (
    input  logic             enable,
    input  logic [BUS_W-1:0] bus,
    input  logic [BUS_W-1:0] lo,
    input  logic [BUS_W-1:0] hi,
    output logic             outside
);
    logic below, above;

    // Compare against each bound separately; either miss is a violation.
    always_comb begin
        below   = bus < lo;
        above   = bus > hi;
        outside = enable && (below || above);
    end
endmodule

// File: rtl/acs_peer_policy.sv
`timescale 1ns/1ps
// Verdict selection. Order: source failure, non-peer routing,
// completion redirect, request blocking, request redirect.
// Assumes src_fail is already gated off for completions.
module acs_peer_policy
    import acs_pkg::*;
(
    input  acs_ctrl_t ctrl,
    input  logic      src_fail,
    input  logic      to_peer,
    input  logic      is_cpl,
    output verdict_e  verdict
);
    // Priority chain; blocking sits above redirect for requests.
    always_comb begin
        if (src_fail)
            verdict = VERD_DISCARD;
        else if (!to_peer)
            verdict = VERD_UPSTREAM;
        else if (is_cpl)
            verdict = ctrl.cpl_redir_en ? VERD_REDIRECT : VERD_PEER;
        else if (ctrl.block_en)
            verdict = VERD_DISCARD;
        else if (ctrl.req_redir_en)
            verdict = VERD_REDIRECT;
        else
            verdict = VERD_PEER;
    end
endmodule

// File: rtl/acs_verdict_stage.sv
`timescale 1ns/1ps
// One-entry output register with valid/ready. Loads a verdict on accept.
// The violation flag becomes a strobe only in the load cycle.
// Assumes res_ready may change at any cycle.
module acs_verdict_stage #(
    parameter int VW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [VW-1:0] in_verdict,
    input  logic          in_flag,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [VW-1:0] out_verdict,
    output logic          out_strobe
);
    logic load;

    // Accept when the register is empty or being drained.
    always_comb begin
        in_ready = !out_valid || out_ready;
        load     = in_valid && in_ready;
    end

    // Hold or replace the verdict and raise the strobe only on a load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid   <= 1'b0;
            out_verdict <= '0;
            out_strobe  <= 1'b0;
        end else begin
            out_strobe <= load && in_flag;
            if (load) begin
                out_valid   <= 1'b1;
                out_verdict <= in_verdict;
            end else if (out_ready) begin
                out_valid <= 1'b0;
            end
        end
    end

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> !out_valid && !out_strobe);
    assert_accept_next_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> out_valid);
    assert_stall_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_verdict));
    assert_strobe_with_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_strobe |-> out_valid);
    assert_strobe_once_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> !out_strobe);
endmodule

// File: rtl/acs_dnport_checker.sv
`timescale 1ns/1ps
// Access checker for upstream-bound headers at a downstream port.
// It validates the requester bus and picks the peer policy, then registers
// the verdict and error strobe. Config inputs are sampled with each header.
module acs_dnport_checker
    import acs_pkg::*;
#(
    parameter int BUS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] cfg_sec_bus,
    input  logic [BUS_W-1:0] cfg_sub_bus,
    input  logic             cfg_src_check_en,
    input  logic             cfg_req_redirect_en,
    input  logic             cfg_cpl_redirect_en,
    input  logic             cfg_peer_block_en,
    input  logic             cfg_violation_mask,
    input  logic             hdr_valid,
    output logic             hdr_ready,
    input  logic [BUS_W-1:0] hdr_req_bus,
    input  logic             hdr_is_cpl,
    input  logic             hdr_to_peer,
    output logic             res_valid,
    input  logic             res_ready,
    output logic [1:0]       res_verdict,
    output logic             acs_violation
);
    localparam int VW = $bits(verdict_e);

    acs_ctrl_t ctrl;
    logic      src_fail;
    logic      flag;
    verdict_e  verdict;

    // Gather the enables into one control word.
    always_comb begin
        ctrl.src_en       = cfg_src_check_en;
        ctrl.req_redir_en = cfg_req_redirect_en;
        ctrl.cpl_redir_en = cfg_cpl_redirect_en;
        ctrl.block_en     = cfg_peer_block_en;
        ctrl.viol_mask    = cfg_violation_mask;
    end

    acs_range_check #(.BUS_W(BUS_W)) u_range (
        .enable  (ctrl.src_en && !hdr_is_cpl),
        .bus     (hdr_req_bus),
        .lo      (cfg_sec_bus),
        .hi      (cfg_sub_bus),
        .outside (src_fail)
    );

    acs_peer_policy u_policy (
        .ctrl     (ctrl),
        .src_fail (src_fail),
        .to_peer  (hdr_to_peer),
        .is_cpl   (hdr_is_cpl),
        .verdict  (verdict)
    );

    // A discard is an error unless masked.
    always_comb flag = (verdict == VERD_DISCARD) && !ctrl.viol_mask;

    acs_verdict_stage #(.VW(VW)) u_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (hdr_valid),
        .in_ready    (hdr_ready),
        .in_verdict  (verdict),
        .in_flag     (flag),
        .out_valid   (res_valid),
        .out_ready   (res_ready),
        .out_verdict (res_verdict),
        .out_strobe  (acs_violation)
    );

    assert_src_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && hdr_ready && cfg_src_check_en && !hdr_is_cpl &&
        (hdr_req_bus < cfg_sec_bus || hdr_req_bus > cfg_sub_bus)
        |=> res_verdict == 2'b11);
    assert_block_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && hdr_ready && hdr_to_peer && !hdr_is_cpl && cfg_peer_block_en
        |=> res_verdict == 2'b11);
    assert_cpl_never_discard_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && hdr_ready && hdr_is_cpl |=> res_verdict != 2'b11);
    assert_mask_silent_R10: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid && hdr_ready && cfg_violation_mask |=> !acs_violation);
endmodule

// File: tb/tb_acs_dnport_checker.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver queues expected verdicts; the monitor pops them.
module tb_acs_dnport_checker;
    localparam int BUS_W = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [BUS_W-1:0] cfg_sec_bus = 8'h10, cfg_sub_bus = 8'h1F;
    logic cfg_src_check_en = 0, cfg_req_redirect_en = 0, cfg_cpl_redirect_en = 0;
    logic cfg_peer_block_en = 0, cfg_violation_mask = 0;
    logic hdr_valid = 0, hdr_is_cpl = 0, hdr_to_peer = 0;
    logic [BUS_W-1:0] hdr_req_bus = '0;
    logic hdr_ready, res_valid, acs_violation;
    logic res_ready = 1'b1;
    logic [1:0] res_verdict;

    int checks = 0, fails = 0;
    bit stall_mode = 0;
    int cyc = 0;
    logic [1:0] q_verd[$];
    bit         q_viol[$];
    string      q_tag[$];
    bit first_seen = 0;

    always #2.5 clk = ~clk;

    acs_dnport_checker #(.BUS_W(BUS_W)) dut (.*);

    // Consumer: stalls on a fixed pattern when stall_mode is on.
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1 res_ready = stall_mode ? ((cyc % 4) != 1 && (cyc % 4) != 2) : 1'b1;
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model from the requirements.
    function automatic logic [1:0] model(input logic [7:0] bus, input bit cpl, input bit peer);
        if (cfg_src_check_en && !cpl && (bus < cfg_sec_bus || bus > cfg_sub_bus)) return 2'b11; // R3
        if (!peer) return 2'b00;                                                              // R8
        if (cpl) return cfg_cpl_redirect_en ? 2'b10 : 2'b01;                                  // R7
        if (cfg_peer_block_en) return 2'b11;                                                  // R5
        return cfg_req_redirect_en ? 2'b10 : 2'b01;                                           // R6
    endfunction

    task automatic send(input string tag, input logic [7:0] bus, input bit cpl, input bit peer);
        bit r;
        logic [1:0] e;
        hdr_valid = 1; hdr_req_bus = bus; hdr_is_cpl = cpl; hdr_to_peer = peer;
        e = model(bus, cpl, peer);
        forever begin
            @(negedge clk); r = hdr_ready;
            @(posedge clk);
            if (r) break;
        end
        q_verd.push_back(e);
        q_viol.push_back(e == 2'b11 && !cfg_violation_mask); // R9 R10
        q_tag.push_back(tag);
        #1 hdr_valid = 0;
    endtask

    // Monitor: checks the strobe in the first result cycle and the verdict on the handshake.
    always @(negedge clk) begin
        if (rst_n) begin
            if (res_valid && q_verd.size() > 0) begin
                check(hdr_ready == !res_valid || res_ready, "R2 ready", hdr_ready, 1);
                if (!first_seen) begin
                    check(acs_violation == q_viol[0], {"R9 strobe ", q_tag[0]}, acs_violation, q_viol[0]);
                    first_seen = 1;
                end else begin
                    check(!acs_violation, {"R9 single pulse ", q_tag[0]}, acs_violation, 0);
                end
                if (res_ready) begin
                    check(res_verdict == q_verd[0], {"verdict ", q_tag[0]}, res_verdict, q_verd[0]);
                    void'(q_verd.pop_front()); void'(q_viol.pop_front()); void'(q_tag.pop_front());
                    first_seen = 0;
                end
            end else if (res_valid) begin
                check(0, "R2 unexpected result", 1, 0);
            end else begin
                check(!acs_violation, "R9 idle strobe", acs_violation, 0);
            end
        end
    end

    task automatic run_tests();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk);
        check(!res_valid, "R1 res_valid", res_valid, 0);
        check(!acs_violation, "R1 violation", acs_violation, 0);
        check(hdr_ready, "R1 hdr_ready", hdr_ready, 1);
        @(posedge clk); #1;
        cfg_src_check_en = 1;
        send("R8 in window", 8'h15, 0, 0);
        send("R3 below", 8'h0F, 0, 0);
        send("R3 above", 8'h20, 0, 0);
        send("R3 low edge", 8'h10, 0, 0);
        send("R3 high edge", 8'h1F, 0, 0);
        send("R3 peer outside", 8'h40, 0, 1);
        cfg_src_check_en = 0;
        send("R4 disabled", 8'h05, 0, 0);
        send("R4 disabled peer", 8'hF0, 0, 1);
        cfg_src_check_en = 1;
        cfg_peer_block_en = 1; cfg_req_redirect_en = 1;
        send("R5 block over redirect", 8'h12, 0, 1);
        cfg_violation_mask = 1;
        send("R10 masked block", 8'h12, 0, 1);
        send("R10 masked src", 8'h01, 0, 0);
        cfg_violation_mask = 0;
        cfg_peer_block_en = 0;
        send("R6 redirect", 8'h12, 0, 1);
        cfg_req_redirect_en = 0;
        send("R6 direct", 8'h12, 0, 1);
        cfg_peer_block_en = 1; cfg_cpl_redirect_en = 1;
        send("R7 cpl redirect", 8'h12, 1, 1);
        cfg_cpl_redirect_en = 0;
        send("R7 cpl direct under block", 8'h12, 1, 1);
        send("R7 cpl outside window", 8'h05, 1, 1);
        send("R8 cpl upstream", 8'h05, 1, 0);
        stall_mode = 1;
        for (int i = 0; i < 24; i++) begin
            cfg_violation_mask = (i % 5 == 4);
            cfg_peer_block_en  = i[0];
            cfg_req_redirect_en = i[1];
            cfg_cpl_redirect_en = i[2];
            send("R2 R9 stalled stream", 8'(8'h0C + i), i[3], (i % 3) != 0);
        end
        stall_mode = 0;
        cfg_violation_mask = 0;
        repeat (10) @(posedge clk);
        check(q_verd.size() == 0, "R2 all results drained", q_verd.size(), 0);
    endtask

    initial begin
        fork
            run_tests();
            begin
                repeat (20000) @(posedge clk);
                check(0, "watchdog expired", 1, 0);
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule